// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block paces a four-input sampled-data front end. It runs directly on the slot clock, a 32 kHz-class clock in which one cycle is one slot. A frame is a run of conversions followed by a single settle slot. The settle slot gives the reference voltage time to recover after the input-crossing change. The number of conversions per frame and the number of slots each conversion takes come from two configuration inputs. These inputs are sampled only at frame boundaries, so a value that changes in the middle of a frame never produces a partial frame.

The sequencer drives several outputs for the rest of the front end. The mux channel index selects the analog input. A compute-pass start strobe marks the first slot of channel 0. A store strobe marks the slot in which each conversion finishes and its result is due in memory. A frame sync pulse appears in the settle slot. The block also counts completed frames and raises a transfer-busy pulse once per summation interval, which is the product of a pre-summing count and a summing-cycle count.

Top module: `adc_frame_seq`

## Requirements
- R1: A conversion lasts a whole number of slots: 1, 2 or 3 slots for filter code 0, 1 or 2.
- R2: Filter code 3 behaves exactly like code 2 (3 slots per conversion).
- R3: With N conversions of L slots each, frame_sync pulses recur every 1 + N*L slots (13 slots for N = 4, code 2).
- R4: After the last conversion exactly one settle slot follows, with `settle` high. `frame_sync` is high for exactly that one slot, and `settle` is low in every conversion slot.
- R5: `pass_start` is high exactly once per frame, in the first slot of conversion 0.
- R6: `store_strobe` is high in the last slot of each conversion, so the k-th strobe of a frame (k from 1) falls in slot k*L. `store_chan` equals k-1 in that slot.
- R7: During conversion slot c of a frame (c from 1), `mux_chan` equals (c-1)/L, rounded down.
- R8: A conversion count of 0 holds the block in settle. In that state there are no pass starts, no store strobes, no frame_sync and no transfer pulses, until a nonzero count is seen in a settle slot.
- R9: Conversion count, filter code and interval factors are sampled only in a settle slot that starts a frame. A change made during a frame alters only the following frame.
- R10: `xfer_busy` is a one-slot pulse that coincides with `frame_sync` on every (PRE*SUM)-th frame. A factor of 0 counts as 1.
- R11: While `rst_n` is low at a clock edge, the block goes to idle settle: `settle` = 1, `mux_chan` = 0, and all strobes and `frame_sync` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cycle per slot |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_conv_cnt | input | CNT_W | Conversions per frame (0 = hold in settle) |
| cfg_filt_code | input | 2 | Filter-length code: 0/1/2/3 give 1/2/3/3 slots per conversion |
| cfg_pre_cnt | input | PS_W | Pre-summing factor of the transfer interval |
| cfg_sum_cnt | input | SC_W | Summing-cycle factor of the transfer interval |
| mux_chan | output | CNT_W | Index of the conversion in progress |
| settle | output | 1 | High in the settle slot (and while idle) |
| frame_sync | output | 1 | One-slot pulse in the settle slot that ends a frame |
| pass_start | output | 1 | Compute pass start, first slot of conversion 0 |
| store_strobe | output | 1 | Conversion finishes this slot; result to be stored |
| store_chan | output | CNT_W | Conversion index belonging to store_strobe |
| xfer_busy | output | 1 | End-of-summation-interval pulse |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a frame. The change must leave the running frame untouched and shape only the next one. The stimulus aligns on a frame_sync pulse, waits one slot and rewrites every setting, then measures that frame and the next one against the old and new lengths. The transfer interval has no visible phase after reset. The bench therefore first locks onto one transfer pulse and then counts frames to the next pulse. The hold state is reached by lowering the count to 0, and the bench checks that the block restarts cleanly from it.

// File: rtl/adc_seq_pkg.sv
// Shared definitions for the ADC frame sequencer.
// Assumes the filter-length code is two bits wide.
package adc_seq_pkg;

    localparam int FILT_W = 2;   // filter-length code width
    localparam int SLOT_W = 2;   // holds slot counts 1..3

    // Map a filter-length code to slots per conversion; reserved code 3 acts as code 2.
    function automatic logic [SLOT_W-1:0] conv_slots(input logic [FILT_W-1:0] code);
        logic [SLOT_W-1:0] n;
        case (code)
            2'd0:    n = 2'd1;
            2'd1:    n = 2'd2;
            default: n = 2'd3;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/adc_seq_cfg_capture.sv
// Configuration capture for the frame sequencer.
// Samples the live settings when `load` is high (the settle slot that starts a
// frame) and holds them for the whole frame. A zero interval factor counts as 1.
module adc_seq_cfg_capture
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int PS_W  = 4,
    parameter int SC_W  = 4,
    localparam int IV_W = PS_W + SC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  cfg_conv_cnt,
    input  logic [FILT_W-1:0] cfg_filt_code,
    input  logic [PS_W-1:0]   cfg_pre_cnt,
    input  logic [SC_W-1:0]   cfg_sum_cnt,
    output logic [CNT_W-1:0]  conv_cnt_l,
    output logic [SLOT_W-1:0] slots_l,
    output logic [IV_W-1:0]   interval_l
);

    logic [PS_W-1:0] pre_eff;
    logic [SC_W-1:0] sum_eff;
    logic [IV_W-1:0] interval_nxt;

    // Replace zero factors by one and form the summation interval.
    always_comb begin
        pre_eff      = (cfg_pre_cnt == '0) ? PS_W'(1) : cfg_pre_cnt;
        sum_eff      = (cfg_sum_cnt == '0) ? SC_W'(1) : cfg_sum_cnt;
        interval_nxt = IV_W'(pre_eff) * IV_W'(sum_eff);
    end

    // Hold the frame configuration; update only on a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_cnt_l <= '0;
            slots_l    <= SLOT_W'(1);
            interval_l <= IV_W'(1);
        end else if (load) begin
            conv_cnt_l <= cfg_conv_cnt;
            slots_l    <= conv_slots(cfg_filt_code);
            interval_l <= interval_nxt;
        end
    end

    // R9: latched settings never move inside a frame.
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(conv_cnt_l) && $stable(slots_l) && $stable(interval_l)));

    // R2: latched slot count is always 1..3.
    p_slots_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slots_l != 2'd0));

endmodule

// File: rtl/adc_seq_slot_timer.sv
// Slot timer for the frame sequencer.
// Steps through conv_cnt_l conversions of slots_l slots each, then one settle
// slot. Leaves settle only when the live conversion count is nonzero.
// Assumes conv_cnt_l and slots_l are stable for the whole frame.
module adc_seq_slot_timer
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  live_conv_cnt,
    input  logic [CNT_W-1:0]  conv_cnt_l,
    input  logic [SLOT_W-1:0] slots_l,
    output logic              load,
    output logic              settle,
    output logic [CNT_W-1:0]  chan,
    output logic              pass_start,
    output logic              store_strobe,
    output logic              frame_end
);

    logic              settle_q;
    logic              ended_q;
    logic [CNT_W-1:0]  idx_q;
    logic [SLOT_W-1:0] sub_q;
    logic              last_slot;
    logic              last_conv;

    // Decode the slot position inside the frame.
    always_comb begin
        load      = settle_q && (live_conv_cnt != '0);
        last_slot = !settle_q && (sub_q == slots_l - SLOT_W'(1));
        last_conv = (idx_q == conv_cnt_l - CNT_W'(1));
    end

    // Advance slot, conversion index and settle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= 1'b1;
            ended_q  <= 1'b0;
            idx_q    <= '0;
            sub_q    <= '0;
        end else begin
            ended_q <= last_slot && last_conv;
            if (settle_q) begin
                if (load) begin
                    settle_q <= 1'b0;
                    idx_q    <= '0;
                    sub_q    <= '0;
                end
            end else if (last_slot) begin
                sub_q <= '0;
                if (last_conv) begin
                    settle_q <= 1'b1;
                    idx_q    <= '0;
                end else begin
                    idx_q <= idx_q + CNT_W'(1);
                end
            end else begin
                sub_q <= sub_q + SLOT_W'(1);
            end
        end
    end

    // Drive the slot-level strobes.
    always_comb begin
        settle       = settle_q;
        chan         = idx_q;
        pass_start   = !settle_q && (idx_q == '0) && (sub_q == '0);
        store_strobe = last_slot;
        frame_end    = ended_q;
    end

    // R4: the frame pulse appears only in settle and lasts one slot.
    p_sync_in_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> settle_q);
    p_sync_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end);
    // R5: a pass start is never followed by another in the next slot.
    p_pass_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_start |=> !pass_start);
    // R3: the store of the final conversion is followed by the settle slot.
    p_settle_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store_strobe && last_conv) |=> (settle_q && frame_end));
    // R8: without a load, settle persists and nothing is strobed.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (settle_q && !load) |=> (settle_q && !pass_start && !store_strobe));

endmodule

// File: rtl/adc_seq_pass_counter.sv
// Summation-interval counter for the frame sequencer.
// Counts completed frames and flags the frame that closes each interval of
// interval_l frames. A count left above a newly lowered interval closes at once.
module adc_seq_pass_counter #(
    parameter int IV_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_end,
    input  logic [IV_W-1:0] interval_l,
    output logic            xfer_busy
);

    logic [IV_W-1:0] cnt_q;
    logic            hit;

    // Detect the frame that closes the interval.
    always_comb begin
        hit       = frame_end && (cnt_q >= interval_l - IV_W'(1));
        xfer_busy = hit;
    end

    // Count frames, wrap at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (frame_end) begin
            cnt_q <= hit ? '0 : cnt_q + IV_W'(1);
        end
    end

    // R10: a transfer pulse restarts the count.
    p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |=> (cnt_q == '0));
    // R8: with no frame ending the count does not move.
    p_cnt_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(cnt_q));

endmodule

// File: rtl/adc_frame_seq.sv
// ADC multiplexer frame sequencer, top level.
// Clocked by the slot clock. Joins configuration capture, slot timer and
// summation-interval counter. Assumes configuration inputs are synchronous to clk.
module adc_frame_seq
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int PS_W  = 4,
    parameter int SC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_conv_cnt,
    input  logic [1:0]        cfg_filt_code,
    input  logic [PS_W-1:0]   cfg_pre_cnt,
    input  logic [SC_W-1:0]   cfg_sum_cnt,
    output logic [CNT_W-1:0]  mux_chan,
    output logic              settle,
    output logic              frame_sync,
    output logic              pass_start,
    output logic              store_strobe,
    output logic [CNT_W-1:0]  store_chan,
    output logic              xfer_busy
);

    localparam int IV_W = PS_W + SC_W;

    logic              load;
    logic              frame_end;
    logic [CNT_W-1:0]  conv_cnt_l;
    logic [SLOT_W-1:0] slots_l;
    logic [IV_W-1:0]   interval_l;
    logic [CNT_W-1:0]  chan;

    adc_seq_cfg_capture #(.CNT_W(CNT_W), .PS_W(PS_W), .SC_W(SC_W)) i_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .load          (load),
        .cfg_conv_cnt  (cfg_conv_cnt),
        .cfg_filt_code (cfg_filt_code),
        .cfg_pre_cnt   (cfg_pre_cnt),
        .cfg_sum_cnt   (cfg_sum_cnt),
        .conv_cnt_l    (conv_cnt_l),
        .slots_l       (slots_l),
        .interval_l    (interval_l)
    );

    adc_seq_slot_timer #(.CNT_W(CNT_W)) i_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .live_conv_cnt (cfg_conv_cnt),
        .conv_cnt_l    (conv_cnt_l),
        .slots_l       (slots_l),
        .load          (load),
        .settle        (settle),
        .chan          (chan),
        .pass_start    (pass_start),
        .store_strobe  (store_strobe),
        .frame_end     (frame_end)
    );

    adc_seq_pass_counter #(.IV_W(IV_W)) i_pass (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end  (frame_end),
        .interval_l (interval_l),
        .xfer_busy  (xfer_busy)
    );

    // Route the timer outputs to the ports.
    always_comb begin
        mux_chan   = chan;
        store_chan = chan;
        frame_sync = frame_end;
    end

    // R6: a store never happens in the settle slot.
    p_store_not_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        store_strobe |-> !settle);
    // R10: transfer pulses only coincide with the frame pulse.
    p_xfer_on_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy |-> frame_sync);

endmodule

// File: tb/test_adc_frame_seq.sv
// Directed bench for adc_frame_seq: one task per scenario.
module test_adc_frame_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cfg_conv_cnt;
    logic [1:0] cfg_filt_code;
    logic [3:0] cfg_pre_cnt;
    logic [3:0] cfg_sum_cnt;
    logic [3:0] mux_chan;
    logic       settle, frame_sync, pass_start, store_strobe, xfer_busy;
    logic [3:0] store_chan;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    adc_frame_seq i_adc_frame_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_conv_cnt(cfg_conv_cnt), .cfg_filt_code(cfg_filt_code),
        .cfg_pre_cnt(cfg_pre_cnt), .cfg_sum_cnt(cfg_sum_cnt),
        .mux_chan(mux_chan), .settle(settle), .frame_sync(frame_sync),
        .pass_start(pass_start), .store_strobe(store_strobe),
        .store_chan(store_chan), .xfer_busy(xfer_busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int n, input int code, input int pre, input int sum);
        cfg_conv_cnt  = 4'(n);
        cfg_filt_code = 2'(code);
        cfg_pre_cnt   = 4'(pre);
        cfg_sum_cnt   = 4'(sum);
    endtask

    task automatic wait_sync(output bit got);
        got = 1'b0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (frame_sync) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    // Measure one frame starting after a sync slot; l is slots per conversion.
    task automatic measure(input int n, input int l, input string req);
        int  stores = 0, passes = 0, ord_err = 0, chan_err = 0, set_err = 0, c = 0;
        bit  done = 1'b0;
        while (!done && c < 300) begin
            @(negedge clk);
            c++;
            if (pass_start) begin
                passes++;
                if (c != 1 || mux_chan != 0) ord_err++;
            end
            if (store_strobe) begin
                stores++;
                if (c != stores * l || int'(store_chan) != stores - 1) ord_err++;
            end
            if (frame_sync) begin
                done = 1'b1;
                if (!settle) set_err++;
            end else begin
                if (settle) set_err++;
                if (int'(mux_chan) != (c - 1) / l) chan_err++;
            end
        end
        chk(c == 1 + n * l, {req, "/R3"}, "frame length", c, 1 + n * l);
        chk(passes == 1, "R5", "pass starts per frame", passes, 1);
        chk(stores == n, "R6", "store strobes per frame", stores, n);
        chk(ord_err == 0, "R6", "strobe slot/channel errors", ord_err, 0);
        chk(chan_err == 0, "R7", "mux channel errors", chan_err, 0);
        chk(set_err == 0, "R4", "settle slot errors", set_err, 0);
    endtask

    task automatic t_reset();
        bit got;
        set_cfg(4, 2, 1, 1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(settle == 1'b1, "R11", "settle in reset", int'(settle), 1);
        chk(mux_chan == 4'd0, "R11", "mux_chan in reset", int'(mux_chan), 0);
        chk({frame_sync, pass_start, store_strobe, xfer_busy} == 4'b0,
            "R11", "strobes in reset",
            int'({frame_sync, pass_start, store_strobe, xfer_busy}), 0);
        rst_n = 1'b1;
        wait_sync(got);
        chk(got, "R3", "first sync after reset", int'(got), 1);
        chk(xfer_busy == 1'b1, "R10", "interval 1 pulses each frame", int'(xfer_busy), 1);
    endtask

    task automatic t_frame(input int n, input int code, input int l, input string req);
        bit got;
        set_cfg(n, code, 1, 1);
        wait_sync(got);
        measure(n, l, req);
        measure(n, l, req);
    endtask

    task automatic t_midchange();
        bit got;
        int c = 1;
        set_cfg(3, 0, 1, 1);
        wait_sync(got);
        @(negedge clk);
        chk(pass_start == 1'b1, "R9", "pass start after sync", int'(pass_start), 1);
        set_cfg(2, 2, 1, 1);
        while (!frame_sync && c < 100) begin
            @(negedge clk);
            c++;
        end
        chk(c == 4, "R9", "running frame keeps old length", c, 4);
        measure(2, 3, "R9");
    endtask

    task automatic t_idle();
        bit got;
        int bad = 0;
        set_cfg(0, 1, 1, 1);
        wait_sync(got);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!settle || pass_start || store_strobe || frame_sync || xfer_busy) bad++;
        end
        chk(bad == 0, "R8", "activity while held", bad, 0);
        set_cfg(2, 1, 1, 1);
        wait_sync(got);
        chk(got, "R8", "restart after hold", int'(got), 1);
        measure(2, 2, "R8");
    endtask

    task automatic t_xfer(input int pre, input int sum, input int exp);
        bit got;
        int stray = 0, k = 0, seen = 0;
        set_cfg(1, 0, pre, sum);
        wait_sync(got);
        wait_sync(got);
        for (int i = 0; i < 400 && seen < 2; i++) begin
            @(negedge clk);
            if (xfer_busy && !frame_sync) stray++;
            if (frame_sync) begin
                if (seen == 1) k++;
                if (xfer_busy) seen++;
            end
        end
        chk(stray == 0, "R10", "pulse outside sync", stray, 0);
        chk(k == exp, "R10", "frames per interval", k, exp);
    endtask

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected 0 remaining cycles", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        set_cfg(4, 2, 1, 1);
        @(negedge clk);
        t_reset();
        t_frame(4, 2, 3, "R1");
        t_frame(3, 0, 1, "R1");
        t_frame(2, 1, 2, "R1");
        t_frame(5, 3, 3, "R2");
        t_midchange();
        t_idle();
        t_xfer(2, 3, 6);
        t_xfer(0, 5, 5);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule